// File: doc/BRIEF.md
# Parity-Checked GHASH Accumulation Loop

This block runs the hashing loop of an authenticated-encryption mode over GF(2^128). A 128-bit hash key is captured on a start pulse. A stream of 128-bit blocks then follows: the authenticated-only data, the ciphertext, and finally the length block. Each accepted block is XORed into a 128-bit accumulator, and the sum is multiplied by the key in one combinational multiplier. The product is written back into the accumulator. Once the block marked last has been absorbed, the accumulator holds the hash and a one-cycle done pulse announces it.

The multiplier is watched on every accepted block by a concurrent single-bit check. The actual parity of the product is the XOR of its 128 bits. The predicted parity is the XOR of the bits of the multiplier input, each masked by a 128-entry table of parities of key·α^j. The table is built in the 128 cycles after start by walking key·α^j one step per cycle. The block accepts no data during that time. A registered error flag reports a disagreement between the two parities.

Top module: `ghash_parity_loop`

## Requirements
- R1: After reset, `blk_ready`, `done` and `err` are 0 and `hash_out` is all zeros.
- R2: A cycle with `start` = 1 clears the accumulator, so `hash_out` reads zero after that edge. `blk_ready` then stays 0 for exactly 128 further clock edges and is 1 after the 128th.
- R3: An accepted block (`blk_valid` and `blk_ready` both 1, `start` 0) replaces the accumulator Y with (Y xor block)·H reduced modulo x^128 + x^7 + x^2 + x + 1. Bit i of every 128-bit value is the coefficient of α^i. `hash_out` shows Y after that edge.
- R4: `done` is 1 for exactly the one cycle after a block with `blk_last` = 1 is accepted, and `hash_out` then holds the final result. From that edge on, `blk_ready` stays 0 until the next start.
- R5: `err` is registered. It is 0 after every edge with no accepted block. After an accepted block it is 1 only when the predicted and actual parities of the product differ. With a healthy datapath it is therefore 0 after every block.
- R6: When `start` and a valid block coincide while the loop is ready, the restart wins. The block is not absorbed, `hash_out` reads zero and `blk_ready` drops.
- R7: `blk_valid` has no effect while `blk_ready` is 0, either during table build or after done. `hash_out` is unchanged by it.
- R8: H is the value on `key` at the start edge. Later changes on `key` do not affect the hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture key, clear accumulator, begin table build |
| key | input | 128 | Hash key H, sampled on start |
| blk_valid | input | 1 | A block is offered |
| blk_data | input | 128 | Offered block |
| blk_last | input | 1 | Offered block is the final (length) block |
| blk_ready | output | 1 | Loop accepts a block this cycle |
| hash_out | output | 128 | Accumulator value |
| done | output | 1 | One-cycle pulse after the last block is absorbed |
| err | output | 1 | Parity disagreement on the previous accepted block |

## Verification
A restart and a block acceptance can fall in the same cycle. The bench provokes this by raising `start` at the same edge where a valid block is offered to a ready loop. It judges the outcome by a zero `hash_out`, a low `blk_ready`, and a later hash that matches a reference computed with only the new key and the new message. The multiply and the parity comparison are exercised together on every accepted block. The bench computes each product with its own most-significant-first multiplication, then requires both the product and a low `err`.

// File: rtl/ghp_pkg.sv
package ghp_pkg;
  localparam int BLK_W = 128;
  // low part of the reduction polynomial x^7 + x^2 + x + 1
  localparam logic [BLK_W-1:0] RED_LOW = 128'h87;

  // multiply by alpha: shift toward higher powers, fold the carry back
  function automatic logic [BLK_W-1:0] gf_mulx(input logic [BLK_W-1:0] v);
    return {v[BLK_W-2:0], 1'b0} ^ (v[BLK_W-1] ? RED_LOW : '0);
  endfunction

  // least-significant-first shift-and-add product
  function automatic logic [BLK_W-1:0] gf_mul(input logic [BLK_W-1:0] a,
                                              input logic [BLK_W-1:0] b);
    logic [BLK_W-1:0] acc;
    logic [BLK_W-1:0] v;
    acc = '0;
    v   = b;
    for (int i = 0; i < BLK_W; i++) begin
      if (a[i]) acc = acc ^ v;
      v = gf_mulx(v);
    end
    return acc;
  endfunction

  function automatic logic masked_parity(input logic [BLK_W-1:0] d,
                                         input logic [BLK_W-1:0] tbl);
    return ^(d & tbl);
  endfunction
endpackage

// File: rtl/ghp_keytab.sv
module ghp_keytab #(
  parameter int W = ghp_pkg::BLK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] key,
  output logic [W-1:0] hkey,
  output logic [W-1:0] ph_tbl,
  output logic         busy,
  output logic         fin
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  logic [IW-1:0] idx_q;
  logic [W-1:0]  walk_q;
  logic          par_q;

  assign fin = busy && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hkey   <= '0;
      ph_tbl <= '0;
      busy   <= 1'b0;
      idx_q  <= '0;
      walk_q <= '0;
      par_q  <= 1'b0;
    end else if (load) begin
      hkey   <= key;
      walk_q <= key;
      par_q  <= ^key;
      idx_q  <= '0;
      busy   <= 1'b1;
    end else if (busy) begin
      // parity of key*alpha^(j+1) = parity of key*alpha^j xor its top bit
      ph_tbl[idx_q] <= par_q;
      par_q  <= par_q ^ walk_q[W-1];
      walk_q <= ghp_pkg::gf_mulx(walk_q);
      idx_q  <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ghp_parity_check.sv
module ghp_parity_check #(
  parameter int W = ghp_pkg::BLK_W
) (
  input  logic [W-1:0] mul_in,
  input  logic [W-1:0] mul_out,
  input  logic [W-1:0] ph_tbl,
  output logic         pred_par,
  output logic         act_par,
  output logic         mismatch
);
  assign pred_par = ghp_pkg::masked_parity(mul_in, ph_tbl);
  assign act_par  = ^mul_out;
  assign mismatch = pred_par ^ act_par;
endmodule

// File: rtl/ghash_parity_loop.sv
module ghash_parity_loop #(
  parameter int W = ghp_pkg::BLK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] key,
  input  logic         blk_valid,
  input  logic [W-1:0] blk_data,
  input  logic         blk_last,
  output logic         blk_ready,
  output logic [W-1:0] hash_out,
  output logic         done,
  output logic         err
);
  logic [W-1:0] y_q;
  logic [W-1:0] hkey;
  logic [W-1:0] ph_tbl;
  logic [W-1:0] mul_in;
  logic [W-1:0] mul_out;
  logic         running_q;
  logic         init_busy;
  logic         init_fin;
  logic         acc_fire;
  logic         pred_par;
  logic         act_par;
  logic         mismatch;

  ghp_keytab #(.W(W)) u_keytab (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .key    (key),
    .hkey   (hkey),
    .ph_tbl (ph_tbl),
    .busy   (init_busy),
    .fin    (init_fin)
  );

  assign mul_in  = y_q ^ blk_data;
  assign mul_out = ghp_pkg::gf_mul(mul_in, hkey);

  ghp_parity_check #(.W(W)) u_pcheck (
    .mul_in   (mul_in),
    .mul_out  (mul_out),
    .ph_tbl   (ph_tbl),
    .pred_par (pred_par),
    .act_par  (act_par),
    .mismatch (mismatch)
  );

  assign blk_ready = running_q;
  assign acc_fire  = blk_valid && running_q && !start;
  assign hash_out  = y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q       <= '0;
      running_q <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= acc_fire && blk_last;
      err  <= acc_fire && mismatch;
      if (start) begin
        y_q       <= '0;
        running_q <= 1'b0;
      end else begin
        if (init_fin) running_q <= 1'b1;
        if (acc_fire) begin
          y_q <= mul_out;
          if (blk_last) running_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ghp_checker.sv
module ghp_checker #(
  parameter int W = ghp_pkg::BLK_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         blk_last,
  input logic         blk_ready,
  input logic         acc_fire,
  input logic         init_busy,
  input logic         pred_par,
  input logic         act_par,
  input logic         err,
  input logic         done,
  input logic [W-1:0] hash_out
);
  p_ready_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !blk_ready);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (hash_out == '0));

  p_par_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (pred_par == act_par));

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !err);

  p_done_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && blk_last) |=> (done && !blk_ready));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_fire && !start) |=> $stable(hash_out));
endmodule

bind ghash_parity_loop ghp_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .blk_last  (blk_last),
  .blk_ready (blk_ready),
  .acc_fire  (acc_fire),
  .init_busy (init_busy),
  .pred_par  (pred_par),
  .act_par   (act_par),
  .err       (err),
  .done      (done),
  .hash_out  (hash_out)
);

// File: tb/ghash_parity_loop_tb.sv
module ghash_parity_loop_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic         blk_valid = 1'b0;
  logic [127:0] blk_data = '0;
  logic         blk_last = 1'b0;
  logic         blk_ready;
  logic [127:0] hash_out;
  logic         done;
  logic         err;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_y;
  logic [127:0] cur_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  ghash_parity_loop u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_last(blk_last),
    .blk_ready(blk_ready), .hash_out(hash_out), .done(done), .err(err)
  );

  // reference product, most significant coefficient first (Horner)
  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    r = '0;
    for (int i = 127; i >= 0; i--) begin
      r = {r[126:0], 1'b0} ^ (r[127] ? 128'h87 : 128'h0);
      if (a[i]) r = r ^ b;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // start pulse plus full table build; key scrambled afterwards (R8)
  task automatic do_start(input logic [127:0] k, input logic with_block);
    int ready_seen;
    @(negedge clk);
    start = 1'b1; key = k;
    blk_valid = with_block; blk_data = 128'hdead_beef; blk_last = 1'b0;
    @(posedge clk); #1;
    check("R2 clear on start", hash_out, '0);
    if (with_block) check("R6 restart wins", {127'b0, blk_ready}, 128'b0);
    @(negedge clk);
    start = 1'b0; key = ~k;
    blk_valid = 1'b1; blk_data = 128'h1234_5678_9abc; // offered while not ready (R7)
    ready_seen = 0;
    for (int c = 0; c < 127; c++) begin
      @(posedge clk); #1;
      if (blk_ready) ready_seen++;
    end
    check("R2 ready low during build", 128'(ready_seen), 128'd0);
    check("R7 no absorb during build", hash_out, '0);
    @(negedge clk);
    blk_valid = 1'b0;
    @(posedge clk); #1;
    check("R2 ready after 128 edges", {127'b0, blk_ready}, 128'd1);
    cur_h = k;
    exp_y = '0;
  endtask

  task automatic send_blk(input logic [127:0] d, input logic last);
    @(negedge clk);
    blk_valid = 1'b1; blk_data = d; blk_last = last;
    @(posedge clk); #1;
    exp_y = ref_mul(exp_y ^ d, cur_h);
    check("R3 product", hash_out, exp_y);
    check("R5 err low", {127'b0, err}, 128'd0);
    check("R4 done timing", {127'b0, done}, {127'b0, last});
    @(negedge clk);
    blk_valid = 1'b0; blk_last = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 ready", {127'b0, blk_ready}, 128'd0);
    check("R1 done/err", {126'b0, done, err}, 128'd0);
    check("R1 hash", hash_out, '0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_message(input logic [127:0] k, input int nblk, input logic [127:0] seed);
    logic [127:0] d;
    do_start(k, 1'b0);
    d = seed;
    for (int b = 0; b < nblk; b++) begin
      send_blk(d, b == nblk - 1);
      d = {d[126:0], d[127] ^ d[125] ^ d[100] ^ d[98]} ^ 128'h5;
    end
    // after done: one quiet edge
    @(posedge clk); #1;
    check("R4 done single pulse", {127'b0, done}, 128'd0);
    check("R4 ready low after done", {127'b0, blk_ready}, 128'd0);
    check("R5 err quiet idle", {127'b0, err}, 128'd0);
  endtask

  task automatic t_after_done_ignored();
    logic [127:0] held;
    held = hash_out;
    @(negedge clk);
    blk_valid = 1'b1; blk_data = 128'hffff; blk_last = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 ignored after done", hash_out, held);
    check("R7 no done when not ready", {127'b0, done}, 128'd0);
    @(negedge clk);
    blk_valid = 1'b0; blk_last = 1'b0;
  endtask

  task automatic t_start_override();
    do_start(128'h0f0f_1111_2222_3333_4444_5555_6666_7777, 1'b0);
    send_blk(128'habc, 1'b0);
    // start coincides with a valid block while ready (R6)
    do_start(128'h8000_0000_0000_0000_0000_0000_0000_0001, 1'b1);
    send_blk(128'h1, 1'b0);
    send_blk(128'h8000_0000_0000_0000_0000_0000_0000_0000, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_message(128'h2, 1, 128'h1);                               // R3: alpha*1
    t_message(128'h8000_0000_0000_0000_0000_0000_0000_0000, 3,
              128'h8000_0000_0000_0000_0000_0000_0000_0000);    // R3: reduction path
    t_message('1, 4, '1);                                       // R3 R5: dense operands
    t_message(128'h66e9_4bd4_ef8a_2c3b_884c_fa59_ca34_2b2e, 6,
              128'h0388_dace_60b6_a392_f328_c2b9_71b2_fe78);    // R8: key scrambled after start
    t_after_done_ignored();
    t_start_override();
    finish_run();
  end
endmodule